// File: doc/BRIEF.md
# Word-Scaled Effective Address Unit

This block is the address stage of a 16-bit load/store pipeline whose memory is addressed in bytes. Each cycle it may take one instruction word and the value of the base register that the instruction selects. It recognises three instructions: word load, word store and trap. From these it forms a byte effective address, a code for the access type, and the index of the register that is loaded or stored. All of these are registered and appear with a valid flag one cycle later.

For word load and word store, the signed 6-bit immediate counts 16-bit words. The hardware doubles it before adding it to the base, so the encoder places the word count in the field unchanged. The field then covers -64 to +62 bytes, twice the reach of a plain byte offset. For a trap, the 8-bit vector is zero-extended and doubled to give the byte address of a two-byte table entry. A word access uses two bytes, with the low byte first, so the unit also outputs the address of the second byte. Any other opcode gives no valid result.

Top module: `word_scaled_agu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `out_addr`=0, `out_kind`=0 and `out_reg`=0.
- R2: A word load (instr[15:12]=0110) produces `out_kind`=01, `out_reg`=instr[11:9] and `out_addr` = base + 2*sext(instr[5:0]).
- R3: The 6-bit offset is two's complement in words. Field 100000 subtracts 64 bytes and field 011111 adds 62 bytes. Instruction 0x6020 is a load of R0 from R0 minus 32 words.
- R4: A word store (instr[15:12]=0111) produces `out_kind`=10, `out_reg`=instr[11:9] (the source register) and the same address arithmetic as R2.
- R5: A trap (instr[15:12]=1111) produces `out_kind`=11, `out_reg`=0 and `out_addr` = 2*zext(instr[7:0]), which lies in 0x0000..0x01FE. `base` has no effect on a trap.
- R6: The address addition wraps modulo 2^16 and raises no flag.
- R7: `out_addr_hi` always equals `out_addr`+1 modulo 2^16. This is the address of the high byte of a little-endian word whose low byte sits at `out_addr`.
- R8: An accepted instruction with any other opcode gives `out_valid`=0, `out_addr`=0, `out_kind`=0 and `out_reg`=0 on the next cycle.
- R9: The result of an input sampled at one rising edge is visible after that edge. If `in_valid`=0 at an edge, `out_valid` is 0 after it. Back-to-back inputs give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and base are present this cycle |
| instr | input | 16 | Instruction word |
| base | input | 16 | Value of the selected base register |
| out_valid | output | 1 | Registered result is valid |
| out_addr | output | 16 | Byte effective address (address of the low byte) |
| out_addr_hi | output | 16 | Address of the second byte, out_addr+1 |
| out_kind | output | 2 | 00 none, 01 load, 10 store, 11 trap |
| out_reg | output | 3 | Destination register for a load, source register for a store, 0 otherwise |

## Verification
Two effects can land on the same access: a negative word offset and the modulo-2^16 wrap. The bench provokes this with a load at offset -32 words from base 0x0010, which must give 0xFFD0. It also provokes it with a load at offset +1 word from base 0xFFFE, which must wrap to 0x0000. A third case uses base 0xFFFF with offset 0. There the low byte sits at 0xFFFF and the high byte wraps to 0x0000. This is judged by reading both bytes from a byte-wide memory model in the bench and comparing the assembled little-endian word with the expected value.

// File: rtl/word_scaled_agu.sv
module word_scaled_agu #(
  parameter int AW     = 16,
  parameter int OFF_W  = 6,
  parameter int VEC_W  = 8,
  parameter int RIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       instr,
  input  logic [AW-1:0]     base,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic [AW-1:0]     out_addr_hi,
  output logic [1:0]        out_kind,
  output logic [RIDX_W-1:0] out_reg
);
  localparam logic [3:0] OP_LD = 4'b0110;
  localparam logic [3:0] OP_ST = 4'b0111;
  localparam logic [3:0] OP_TR = 4'b1111;
  localparam int OFF_PAD = AW - OFF_W - 1;
  localparam int VEC_PAD = AW - VEC_W - 1;

  wire [3:0] op    = instr[15:12];
  wire       is_ld = (op == OP_LD);
  wire       is_st = (op == OP_ST);
  wire       is_tr = (op == OP_TR);
  wire       hit   = in_valid & (is_ld | is_st | is_tr);

  wire [AW-1:0] off_bytes = {{OFF_PAD{instr[OFF_W-1]}}, instr[OFF_W-1:0], 1'b0};
  wire [AW-1:0] vec_bytes = {{VEC_PAD{1'b0}}, instr[VEC_W-1:0], 1'b0};
  wire [AW-1:0] ea        = is_tr ? vec_bytes : base + off_bytes;

  logic [1:0] kind_d;
  always_comb begin
    kind_d = 2'b00;
    if (is_ld) kind_d = 2'b01;
    if (is_st) kind_d = 2'b10;
    if (is_tr) kind_d = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_kind  <= 2'b00;
      out_reg   <= '0;
    end else begin
      out_valid <= hit;
      out_addr  <= hit ? ea : '0;
      out_kind  <= hit ? kind_d : 2'b00;
      out_reg   <= (hit && !is_tr) ? instr[11:9] : '0;
    end
  end

  assign out_addr_hi = out_addr + {{(AW-1){1'b0}}, 1'b1};
endmodule

module word_scaled_agu_chk #(
  parameter int AW     = 16,
  parameter int RIDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [15:0]       instr,
  input logic [AW-1:0]     base,
  input logic              out_valid,
  input logic [AW-1:0]     out_addr,
  input logic [AW-1:0]     out_addr_hi,
  input logic [1:0]        out_kind,
  input logic [RIDX_W-1:0] out_reg
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !out_valid && out_addr == '0);

  // R9
  idle_gives_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  invalid_is_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_addr == '0 && out_kind == 2'b00 && out_reg == '0);

  // R7
  high_byte_next_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_addr_hi == AW'(out_addr + 1));

  // R5
  trap_in_table_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == 2'b11 |-> !out_addr[0] && out_addr <= 16'h01FE && out_reg == '0);

  // R2
  load_parity_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && instr[15:12] == 4'b0110 |=> out_kind == 2'b01 && out_addr[0] == $past(base[0]));
endmodule

bind word_scaled_agu word_scaled_agu_chk #(.AW(AW), .RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/test_word_scaled_agu.sv
`timescale 1ns/1ps
module test_word_scaled_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] base = '0;
  logic        out_valid;
  logic [15:0] out_addr, out_addr_hi;
  logic [1:0]  out_kind;
  logic [2:0]  out_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  word_scaled_agu i_word_scaled_agu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .base(base),
    .out_valid(out_valid), .out_addr(out_addr), .out_addr_hi(out_addr_hi),
    .out_kind(out_kind), .out_reg(out_reg)
  );

  typedef struct {
    bit          v;
    logic [15:0] a;
    logic [1:0]  k;
    logic [2:0]  r;
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic drive(input bit iv, input logic [15:0] ins, input logic [15:0] b, input string tag);
    exp_t e;
    logic [15:0] off;
    @(negedge clk);
    in_valid = iv; instr = ins; base = b;
    e.tag = tag; e.v = 0; e.a = 0; e.k = 0; e.r = 0;
    off = {{9{ins[5]}}, ins[5:0], 1'b0};
    if (iv) begin
      case (ins[15:12])
        4'b0110: begin e.v = 1; e.k = 2'b01; e.r = ins[11:9]; e.a = b + off; end
        4'b0111: begin e.v = 1; e.k = 2'b10; e.r = ins[11:9]; e.a = b + off; end
        4'b1111: begin e.v = 1; e.k = 2'b11; e.r = 0; e.a = {7'd0, ins[7:0], 1'b0}; end
        default: ;
      endcase
    end
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      exp_t e;
      logic [15:0] ew, aw;
      e = q.pop_front();
      checks++;
      if (out_valid !== e.v || out_addr !== e.a || out_kind !== e.k || out_reg !== e.r) begin
        errors++;
        $display("FAIL %s: got v=%0b a=%h k=%b r=%0d expected v=%0b a=%h k=%b r=%0d",
                 e.tag, out_valid, out_addr, out_kind, out_reg, e.v, e.a, e.k, e.r);
      end
      if (e.v) begin
        // R7 little-endian word from the byte memory model
        ew = {mem_byte(e.a + 16'd1), mem_byte(e.a)};
        aw = {mem_byte(out_addr_hi), mem_byte(out_addr)};
        checks++;
        if (aw !== ew) begin
          errors++;
          $display("FAIL R7 %s: word got %h expected %h", e.tag, aw, ew);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_addr !== 16'h0 || out_kind !== 2'b00 || out_reg !== 3'd0) begin
      errors++;
      $display("FAIL R1: got v=%0b a=%h k=%b r=%0d expected 0 0000 00 0", out_valid, out_addr, out_kind, out_reg);
    end
    rst = 1'b0;
    drive(1, 16'h6020, 16'h1000, "R3 0x6020 minus 32 words");
    drive(1, 16'h6A5F, 16'h2000, "R3 plus 31 words");
    drive(1, 16'h6C83, 16'h0400, "R2 load r6 offset 3");
    drive(1, 16'h7E45, 16'h0100, "R4 store r7");
    drive(1, 16'h7270, 16'h8000, "R4 store negative offset");
    drive(1, 16'hF0FF, 16'hABCD, "R5 trap max vector");
    drive(1, 16'hF000, 16'hFFFF, "R5 trap zero vector");
    drive(1, 16'hFE25, 16'h1234, "R5 trap ignores base and upper bits");
    drive(1, 16'h6020, 16'h0010, "R6 negative wrap");
    drive(1, 16'h6001, 16'hFFFE, "R6 positive wrap");
    drive(1, 16'h6000, 16'hFFFF, "R7 high byte wraps");
    drive(1, 16'h1234, 16'h4444, "R8 unknown opcode");
    drive(1, 16'h5FFF, 16'h0002, "R8 opcode 0101");
    drive(0, 16'h6020, 16'h1000, "R9 idle input");
    drive(1, 16'h7001, 16'h0000, "R9 back to back 1");
    drive(1, 16'h6FFF, 16'h0000, "R9 back to back 2");
    @(negedge clk);
    in_valid = 0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_addr !== 16'h0) begin
      errors++;
      $display("FAIL R1 mid-run reset: got v=%0b a=%h expected 0 0000", out_valid, out_addr);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule